// File: doc/BRIEF.md
# Dual-Width Arithmetic Condition Code Register

This block is the 16-bit status register of a DSP-style datapath. After each ALU operation it captures four condition codes (carry, overflow, zero, negative) from a 36-bit result. It also stores a loop flag, a two-bit interrupt mask and four further status bits on behalf of neighbouring units. A single mode input sets the width the flags describe. With mode 0 the flags see the full 36-bit result. With mode 1 they see only its low 32 bits. The datapath itself does not change.

The ALU supplies the result, the operand sign bits at both widths, the carry-out and borrow indications at both widths, a carry produced by bit or shift operations, and a two-bit operation class. An update strobe loads the condition codes. A software write port loads the whole register, and it wins over the strobe in the same cycle. The read port gives the register with its reserved bits held at zero.

Top module: `ccsr_top`

## Requirements
- R1: The condition codes sit at fixed positions in the register: carry at bit 0, overflow at bit 1, zero at bit 2, negative at bit 3.
- R2: While reset is high and in the first cycle after it, the register reads 16'h0300.
- R3: Bits 14 down to 10 always read zero, and software writes to them have no effect.
- R4: For an add (op class 2'b01), carry takes the carry-out indication. For a subtract (op class 2'b10), it takes the borrow indication. Index 1 of each indication is the bit-35 value and is used in mode 0. Index 0 is the bit-31 value and is used in mode 1.
- R5: Overflow is set for an add when both operand signs match and the result sign differs from them. It is set for a subtract when the operand signs differ and the result sign differs from the minuend (operand A). Signs are taken at bit 35 in mode 0 and at bit 31 in mode 1. For any other class overflow is cleared.
- R6: Zero is set only when result bits 35:0 (mode 0) or 31:0 (mode 1) are all zero.
- R7: Negative takes result bit 35 in mode 0 and result bit 31 in mode 1.
- R8: For a bit/shift operation (op class 2'b11), carry takes the bit/shift carry input. For op class 2'b00, carry is cleared. Carry-out and borrow indications are ignored for both classes.
- R9: A software write loads bits 15 and 9:0 from the write data on the next edge, and the update strobe in the same cycle is ignored.
- R10: The loop flag (bit 15), the interrupt mask (bits 9:8) and the status bits 7:4 change only through software writes. With neither strobe nor write, the whole register holds.
- R11: A strobe loads the new condition codes, and they are visible on the read port in the cycle after the strobe's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_narrow | input | 1 | 0: flags from 36 bits; 1: flags from low 32 bits |
| upd | input | 1 | Load condition codes from the current operation |
| op_class | input | 2 | 00 other, 01 add, 10 subtract, 11 bit/shift |
| alu_res | input | 36 | ALU result |
| sign_a | input | 2 | Operand A sign: [1] bit 35, [0] bit 31 |
| sign_b | input | 2 | Operand B sign: [1] bit 35, [0] bit 31 |
| cy_out | input | 2 | Carry-out of add: [1] from bit 35, [0] from bit 31 |
| bw_out | input | 2 | Borrow of subtract: [1] from bit 35, [0] from bit 31 |
| bitop_cy | input | 1 | Carry produced by a bit/shift operation |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 16 | Software write data |
| rd_data | output | 16 | Register contents, reserved bits zero |

## Verification
Some properties are checked by assertions on every cycle. The reserved field always reads zero. A software write always lands as masked data one edge later, whatever the strobe does. The control and status bits hold unless written. The register is frozen when idle. Negative and zero follow the result bit selected by the mode one edge after a strobe. Carry and overflow selection is shown by the bench vectors: add and subtract carries that overflow at one width but not the other, sign patterns chosen to overflow only at 32 or only at 36 bits, and stray carry and borrow inputs presented with the wrong class. The bench also drives reset values and write/strobe collisions.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;

  typedef enum logic [1:0] {
    OPC_OTHER = 2'b00,
    OPC_ADD   = 2'b01,
    OPC_SUB   = 2'b10,
    OPC_BITSH = 2'b11
  } op_class_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic cy;
  } cc_flags_t;

  localparam int SR_W        = 16;
  localparam int CC_W        = 4;
  localparam logic [SR_W-1:0] SR_RST_VAL  = 16'h0300;
  // bit 15 loop flag, bits 9:8 interrupt mask, 7:4 status, 3:0 condition codes
  localparam logic [SR_W-1:0] SR_WR_MASK  = 16'h83FF;
  localparam logic [SR_W-1:0] SR_RSV_MASK = 16'h7C00;

endpackage

// File: rtl/ccsr_lane.sv
module ccsr_lane
  import ccsr_pkg::*;
#(
  parameter int LANE_W = 36
) (
  input  logic [LANE_W-1:0] res,
  input  logic              sa,
  input  logic              sb,
  input  logic              cy,
  input  logic              bw,
  input  logic              bitop_cy,
  input  op_class_e         opc,
  output cc_flags_t         flags
);

  logic sr;
  logic ovf_add, ovf_sub;

  assign sr      = res[LANE_W-1];
  assign ovf_add = (sa == sb) && (sr != sa);
  assign ovf_sub = (sa != sb) && (sr != sa);

  always_comb begin
    flags.neg  = sr;
    flags.zero = (res == '0);
    flags.ovf  = 1'b0;
    flags.cy   = 1'b0;
    unique case (opc)
      OPC_ADD: begin
        flags.cy  = cy;
        flags.ovf = ovf_add;
      end
      OPC_SUB: begin
        flags.cy  = bw;
        flags.ovf = ovf_sub;
      end
      OPC_BITSH: flags.cy = bitop_cy;
      default:   flags.cy = 1'b0;
    endcase
  end

endmodule

// File: rtl/ccsr_flag_sel.sv
module ccsr_flag_sel
  import ccsr_pkg::*;
#(
  parameter int RES_W    = 36,
  parameter int NARROW_W = 32
) (
  input  logic             mode_narrow,
  input  logic [RES_W-1:0] res,
  input  logic [1:0]       sign_a,
  input  logic [1:0]       sign_b,
  input  logic [1:0]       cy_out,
  input  logic [1:0]       bw_out,
  input  logic             bitop_cy,
  input  op_class_e        opc,
  output cc_flags_t        flags
);

  localparam int N_LANES = 2;

  cc_flags_t lane_flags [N_LANES];

  // lane 0 describes the narrow width, lane 1 the full width
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : RES_W;
    ccsr_lane #(.LANE_W(LW)) u_lane (
      .res      (res[LW-1:0]),
      .sa       (sign_a[g]),
      .sb       (sign_b[g]),
      .cy       (cy_out[g]),
      .bw       (bw_out[g]),
      .bitop_cy (bitop_cy),
      .opc      (opc),
      .flags    (lane_flags[g])
    );
  end

  assign flags = mode_narrow ? lane_flags[0] : lane_flags[1];

endmodule

// File: rtl/ccsr_store.sv
module ccsr_store
  import ccsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  cc_flags_t       flags,
  input  logic            sw_we,
  input  logic [SR_W-1:0] sw_wdata,
  output logic [SR_W-1:0] sr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= SR_RST_VAL;
    end else if (sw_we) begin
      sr_q <= sw_wdata & SR_WR_MASK;
    end else if (upd) begin
      sr_q[CC_W-1:0] <= flags;
    end
  end

  // R3: reserved field never reads nonzero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (sr_q & SR_RSV_MASK) == '0);

  // R9: a write lands next edge regardless of the strobe
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> sr_q == ($past(sw_wdata) & SR_WR_MASK));

  // R10: control and status bits move only on a write
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(sr_q[SR_W-1:CC_W]));

  // R10: idle register is frozen
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !upd) |=> $stable(sr_q));

endmodule

// File: rtl/ccsr_top.sv
module ccsr_top
  import ccsr_pkg::*;
#(
  parameter int RES_W    = 36,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_narrow,
  input  logic             upd,
  input  logic [1:0]       op_class,
  input  logic [RES_W-1:0] alu_res,
  input  logic [1:0]       sign_a,
  input  logic [1:0]       sign_b,
  input  logic [1:0]       cy_out,
  input  logic [1:0]       bw_out,
  input  logic             bitop_cy,
  input  logic             sw_we,
  input  logic [15:0]      sw_wdata,
  output logic [15:0]      rd_data
);

  cc_flags_t new_flags;
  op_class_e opc;

  assign opc = op_class_e'(op_class);

  ccsr_flag_sel #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_sel (
    .mode_narrow (mode_narrow),
    .res         (alu_res),
    .sign_a      (sign_a),
    .sign_b      (sign_b),
    .cy_out      (cy_out),
    .bw_out      (bw_out),
    .bitop_cy    (bitop_cy),
    .opc         (opc),
    .flags       (new_flags)
  );

  ccsr_store u_store (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd),
    .flags    (new_flags),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .sr_q     (rd_data)
  );

  // R7: negative follows the mode-selected sign bit
  a_r7_negative: assert property (@(posedge clk) disable iff (rst)
    (upd && !sw_we) |=> rd_data[3] ==
      ($past(mode_narrow) ? $past(alu_res[NARROW_W-1]) : $past(alu_res[RES_W-1])));

  // R6: zero follows the mode-selected slice
  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    (upd && !sw_we) |=> rd_data[2] ==
      ($past(mode_narrow) ? ($past(alu_res[NARROW_W-1:0]) == '0)
                          : ($past(alu_res) == '0)));

endmodule

// File: tb/tb_ccsr_top.sv
module tb_ccsr_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_narrow = 1'b0, upd = 1'b0, bitop_cy = 1'b0, sw_we = 1'b0;
  logic [1:0]  op_class = 2'b00, sign_a = 2'b00, sign_b = 2'b00, cy_out = 2'b00, bw_out = 2'b00;
  logic [35:0] alu_res = '0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ccsr_top dut (
    .clk(clk), .rst(rst), .mode_narrow(mode_narrow), .upd(upd),
    .op_class(op_class), .alu_res(alu_res), .sign_a(sign_a), .sign_b(sign_b),
    .cy_out(cy_out), .bw_out(bw_out), .bitop_cy(bitop_cy),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .rd_data(rd_data)
  );

  localparam int NV = 16;
  // per vector: mode, op, result, sign_a, sign_b, cy, bw, bitop carry, expected {N,Z,V,C}
  localparam logic        V_MODE [NV] = '{0,1,1,0, 0,1,0, 0,0,1, 1,1, 0, 0,1,0};
  localparam logic [1:0]  V_OP   [NV] = '{1,1,1,1, 2,2,2, 1,1,1, 3,3, 0, 1,1,1};
  localparam logic [35:0] V_RES  [NV] = '{36'h8_0000_0000, 36'h8_0000_0000, 36'h0_8000_0000, 36'h0_8000_0000,
                                          36'hF_FFFF_FFFF, 36'h0_7FFF_FFFF, 36'h0_7FFF_FFFF,
                                          36'h0, 36'h1_0000_0000, 36'h1_0000_0000,
                                          36'h5, 36'h5, 36'h8_0000_0000,
                                          36'h1, 36'h1, 36'h3};
  // sign bits: [1]=bit35, [0]=bit31
  localparam logic [1:0]  V_SA   [NV] = '{2'b01,2'b01,2'b00,2'b00, 2'b00,2'b01,2'b01, 0,0,0, 0,0, 2'b01, 0,0,0};
  localparam logic [1:0]  V_SB   [NV] = '{0,0,0,0, 0,0,0, 0,0,0, 0,0, 0, 0,0,0};
  localparam logic [1:0]  V_CY   [NV] = '{2'b00,2'b01,2'b00,2'b00, 2'b00,2'b00,2'b00, 0,0,0, 2'b11,2'b11, 2'b11, 2'b01,2'b10,2'b00};
  localparam logic [1:0]  V_BW   [NV] = '{0,0,0,0, 2'b11,2'b00,2'b00, 0,0,0, 2'b11,2'b00, 2'b11, 0,0,2'b11};
  localparam logic        V_BCY  [NV] = '{0,0,0,0, 0,0,0, 0,0,0, 1,0, 1, 0,0,0};
  localparam logic [3:0]  V_EXP  [NV] = '{4'b1010, 4'b0101, 4'b1010, 4'b0000,
                                          4'b1001, 4'b0010, 4'b0000,
                                          4'b0100, 4'b0000, 4'b0100,
                                          4'b0001, 4'b0000, 4'b1000,
                                          4'b0000, 4'b0000, 4'b0000};
  // requirement each vector targets
  localparam string V_REQ [NV] = '{"R5","R4","R5","R7","R4","R5","R5","R6","R6","R6",
                                   "R8","R8","R8","R4","R4","R4"};

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R2", 16'h0300);
    tick();
    rst = 1'b0;
    check("R2", 16'h0300);
    tick();
    check("R10", 16'h0300);

    // R1 R4 R5 R6 R7 R8 R11 table walk; upper bits remain at reset value
    for (int i = 0; i < NV; i++) begin
      mode_narrow = V_MODE[i]; op_class = V_OP[i]; alu_res = V_RES[i];
      sign_a = V_SA[i]; sign_b = V_SB[i]; cy_out = V_CY[i]; bw_out = V_BW[i];
      bitop_cy = V_BCY[i]; upd = 1'b1;
      tick();
      upd = 1'b0;
      check(V_REQ[i], {12'h030, V_EXP[i]});
    end

    // R10: idle holds last flags
    alu_res = 36'h8_0000_0000; op_class = 2'b01; cy_out = 2'b11;
    tick();
    check("R10", 16'h0300);

    // R3 R9: write all ones, reserved masked
    sw_wdata = 16'hFFFF; sw_we = 1'b1;
    tick();
    sw_we = 1'b0;
    check("R3", 16'h83FF);

    // R10: strobe does not touch control/status bits
    mode_narrow = 1'b0; op_class = 2'b00; alu_res = 36'h0; upd = 1'b1;
    tick();
    upd = 1'b0;
    check("R10", 16'h83F4);

    // R9: write and strobe together, write wins for flags
    sw_wdata = 16'h0000; sw_we = 1'b1; upd = 1'b1;
    op_class = 2'b01; alu_res = 36'h8_0000_0000; sign_a = 2'b10; sign_b = 2'b00; cy_out = 2'b11;
    tick();
    sw_we = 1'b0; upd = 1'b0;
    check("R9", 16'h0000);

    // R3: reserved-only write reads zero
    sw_wdata = 16'h7C00; sw_we = 1'b1;
    tick();
    sw_we = 1'b0;
    check("R3", 16'h0000);

    // R1: condition code positions after a write of a pattern
    sw_wdata = 16'h8105; sw_we = 1'b1;
    tick();
    sw_we = 1'b0;
    check("R1", 16'h8105);

    // R11: strobe result visible one cycle later, upper bits kept
    mode_narrow = 1'b1; op_class = 2'b10; alu_res = 36'h0_0000_0000;
    sign_a = 2'b00; sign_b = 2'b00; bw_out = 2'b01; upd = 1'b1;
    tick();
    upd = 1'b0;
    check("R11", 16'h8105);

    // R2: reset mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R2", 16'h0300);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule